// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block collects interrupt events for a small microcontroller core and turns them into one request with a vector number. It watches four kinds of source. The first is an external pin with a selectable sense. The second is a bank of pins that share one change flag. The last two are timer compare-match and overflow pulses from two timers. Each source has a flag and a mask bit. Software reads and writes these through a byte-wide register port, and clears a flag by writing one to its bit.

A request is raised only when the global interrupt enable is one. Among the pending, enabled sources, the one with the lowest vector number is chosen. The handshake runs on a two-state machine. In `ST_IDLE` nothing is requested. The transition `IDLE->REQ` happens when an enabled source is pending and the global enable is set, and at that point the winning vector is latched. In `ST_REQ` the request is held with a stable vector. The transition `REQ->IDLE (ack)` happens when the core acknowledges: the serviced flag and the global enable are cleared, and the core sets the enable again on return. The transition `REQ->IDLE (withdraw)` happens when the global enable drops or the latched source stops being pending.

The external pin and the change pins pass through a two-flop synchroniser. Edge detection compares the synchronised value with one more registered copy.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every mask bit, every flag, the global enable and the request output are zero.
- R2: The register map is as follows. Address 0x3B is the general mask: bit 6 enables the external source and bit 5 enables pin change. Address 0x3A is the general flag register, with the same two bit positions. Address 0x39 is the timer mask: bit 6 is compare match, bit 2 is timer-1 overflow and bit 1 is timer-0 overflow. Address 0x38 is the timer flag register, with the same bit positions. All other bits, and all other addresses, read zero, and writes to them have no effect.
- R3: Writing a one to a flag bit clears that flag, and writing a zero leaves it unchanged. If a set event and a write-one-clear arrive in the same cycle, the flag stays set.
- R4: A request is raised only while the source's mask bit and the global enable are both one. If the source stops being pending before acknowledge, the request is withdrawn.
- R5: When several enabled sources are pending, the lowest vector wins. The vectors are: 1 external, 2 pin change, 3 compare match, 4 timer-1 overflow, 5 timer-0 overflow.
- R6: An acknowledge while the request is high does three things. It clears the flag of the vector being reported, clears the global enable and drops the request. The vector does not change while the request is held without acknowledge.
- R7: The external sense input selects the external mode: 00 low level, 01 any change, 10 falling edge, 11 rising edge. In the edge modes the external flag is set by the selected edge of the synchronised pin, and other edges leave it clear.
- R8: In low-level mode the external flag reads zero. The external request follows the synchronised pin: it is raised while the pin is low and dropped while the pin is high.
- R9: A change of level on any one or more pin-change inputs sets the single pin-change flag.
- R10: A one-cycle pulse on a timer event input sets that timer's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| gie | output | 1 | Global interrupt enable |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_sense | input | 2 | External sense mode |
| pc_pins | input | 6 | Pin-change inputs (asynchronous) |
| tmr_cmp | input | 1 | Compare-match event pulse |
| tmr1_ovf | input | 1 | Timer-1 overflow pulse |
| tmr0_ovf | input | 1 | Timer-0 overflow pulse |
| irq | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Vector number of the request |
| irq_ack | input | 1 | Acknowledge from the core |

## Verification
The assertions assume four things about the inputs. The core raises the acknowledge only while the request is high. Each timer event input is a single-cycle pulse. The sense input changes only while the external pin is stable. All pins are low during reset, so the first synchronised sample does not look like an edge. The stimulus drives every input at the falling clock edge. It pulses the acknowledge for one cycle only after seeing the request high, and it holds the pins low through reset. Timer pulses and global-enable writes are always one cycle long.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC = 5;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = $clog2(NSRC + 1);

    // source index = vector number - 1 (index 0 has top priority)
    localparam int SRC_EXT = 0;
    localparam int SRC_PC  = 1;
    localparam int SRC_CMP = 2;
    localparam int SRC_T1  = 3;
    localparam int SRC_T0  = 4;

    // bit position of each source inside its mask and flag bytes
    localparam int BIT_POS [NSRC] = '{6, 5, 6, 2, 1};
    // sources from SRC_CMP upward live in the timer register pair
    localparam int FIRST_TIMER_SRC = SRC_CMP;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } irqc_state_e;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } irqc_sense_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta   <= d;
            q      <= meta;
            q_prev <= q;
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [5:0]  GMSK_ADR = 6'h3B,
    parameter logic [5:0]  GFLG_ADR = 6'h3A,
    parameter logic [5:0]  TMSK_ADR = 6'h39,
    parameter logic [5:0]  TFLG_ADR = 6'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic [NSRC-1:0]   set_ev,
    input  logic [NSRC-1:0]   ack_clr,
    input  logic              level_mode,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   flag_q,
    output logic [7:0]        reg_rdata
);
    localparam logic [ADDR_W-1:0] A_GMSK = ADDR_W'(GMSK_ADR);
    localparam logic [ADDR_W-1:0] A_GFLG = ADDR_W'(GFLG_ADR);
    localparam logic [ADDR_W-1:0] A_TMSK = ADDR_W'(TMSK_ADR);
    localparam logic [ADDR_W-1:0] A_TFLG = ADDR_W'(TFLG_ADR);

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[7], reg_wdata[4:3], reg_wdata[0]};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam bit IS_TMR = (i >= FIRST_TIMER_SRC);
        localparam logic [ADDR_W-1:0] MA = IS_TMR ? A_TMSK : A_GMSK;
        localparam logic [ADDR_W-1:0] FA = IS_TMR ? A_TFLG : A_GFLG;
        logic w_mask, w_clr;

        assign w_mask = reg_wr && (reg_addr == MA);
        assign w_clr  = reg_wr && (reg_addr == FA) && reg_wdata[BIT_POS[i]];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (w_mask) begin
                mask_q[i] <= reg_wdata[BIT_POS[i]];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if ((i == SRC_EXT) && level_mode) begin
                flag_q[i] <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q[i] <= 1'b1;
            end else if (w_clr || ack_clr[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        for (int i = 0; i < NSRC; i++) begin
            if (reg_addr == ((i >= FIRST_TIMER_SRC) ? A_TMSK : A_GMSK)) begin
                reg_rdata[BIT_POS[i]] = mask_q[i];
            end
            if (reg_addr == ((i >= FIRST_TIMER_SRC) ? A_TFLG : A_GFLG)) begin
                reg_rdata[BIT_POS[i]] = flag_q[i];
            end
        end
    end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend,
    input  logic             gie_wr,
    input  logic             gie_wdata,
    input  logic             ack,
    output logic             gie_q,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic [NSRC-1:0]  clr
);
    irqc_state_e      state, state_nx;
    logic [IDX_W-1:0] win_idx, cur_idx;

    // lowest index wins
    always_comb begin
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) win_idx = IDX_W'(i);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (gie_q && (|pend))                  state_nx = ST_REQ;
            ST_REQ:  if (ack || !gie_q || !pend[cur_idx])   state_nx = ST_IDLE;
            default:                                        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) cur_idx <= win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (state == ST_REQ && ack) begin
            gie_q <= 1'b0;
        end else if (gie_wr) begin
            gie_q <= gie_wdata;
        end
    end

    always_comb begin
        irq = 1'b0;
        clr = '0;
        unique case (state)
            ST_IDLE: irq = 1'b0;
            ST_REQ: begin
                irq = 1'b1;
                if (ack) clr[cur_idx] = 1'b1;
            end
            default: irq = 1'b0;
        endcase
    end

    assign vec = VEC_W'(cur_idx) + VEC_W'(1);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int         PC_PINS  = 6,
    parameter int         ADDR_W   = 6,
    parameter logic [5:0] GMSK_ADR = 6'h3B,
    parameter logic [5:0] GFLG_ADR = 6'h3A,
    parameter logic [5:0] TMSK_ADR = 6'h39,
    parameter logic [5:0] TFLG_ADR = 6'h38
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    output logic               gie,
    input  logic               ext_pin,
    input  logic [1:0]         ext_sense,
    input  logic [PC_PINS-1:0] pc_pins,
    input  logic               tmr_cmp,
    input  logic               tmr1_ovf,
    input  logic               tmr0_ovf,
    output logic               irq,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               irq_ack
);
    logic               ext_s, ext_p;
    logic [PC_PINS-1:0] pc_s, pc_p;
    logic               ext_evt, level_mode;
    logic [NSRC-1:0]    set_ev, clr, pend, mask_q, flag_q;
    irqc_sense_e        sense;

    irqc_sync #(.W(1)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s), .q_prev(ext_p)
    );

    irqc_sync #(.W(PC_PINS)) u_sync_pc (
        .clk(clk), .rst_n(rst_n), .d(pc_pins), .q(pc_s), .q_prev(pc_p)
    );

    assign sense      = irqc_sense_e'(ext_sense);
    assign level_mode = (sense == SENSE_LOW);

    always_comb begin
        unique case (sense)
            SENSE_ANY:  ext_evt = ext_s ^ ext_p;
            SENSE_FALL: ext_evt = ext_p & ~ext_s;
            SENSE_RISE: ext_evt = ext_s & ~ext_p;
            default:    ext_evt = 1'b0;
        endcase
    end

    assign set_ev[SRC_EXT] = ext_evt;
    assign set_ev[SRC_PC]  = |(pc_s ^ pc_p);
    assign set_ev[SRC_CMP] = tmr_cmp;
    assign set_ev[SRC_T1]  = tmr1_ovf;
    assign set_ev[SRC_T0]  = tmr0_ovf;

    irqc_regs #(
        .ADDR_W(ADDR_W), .GMSK_ADR(GMSK_ADR), .GFLG_ADR(GFLG_ADR),
        .TMSK_ADR(TMSK_ADR), .TFLG_ADR(TFLG_ADR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .set_ev(set_ev), .ack_clr(clr),
        .level_mode(level_mode), .mask_q(mask_q), .flag_q(flag_q),
        .reg_rdata(reg_rdata)
    );

    always_comb begin
        pend = flag_q & mask_q;
        if (level_mode) pend[SRC_EXT] = ~ext_s & mask_q[SRC_EXT];
    end

    irqc_arb u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .gie_wr(gie_wr),
        .gie_wdata(gie_wdata), .ack(irq_ack), .gie_q(gie), .irq(irq),
        .vec(irq_vec), .clr(clr)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int         ADDR_W   = 6,
    parameter logic [5:0] GFLG_ADR = 6'h3A,
    parameter logic [5:0] TMSK_ADR = 6'h39
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [1:0]        ext_sense,
    input logic              tmr_cmp,
    input logic              flag_ext,
    input logic              flag_cmp,
    input logic              gie,
    input logic              irq,
    input logic [2:0]        irq_vec,
    input logic              irq_ack
);
    // R2: reserved bits of the general flag and timer mask read zero
    a_r2_gflag_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(GFLG_ADR)) |-> ((reg_rdata & 8'h9F) == 8'h00));
    a_r2_tmask_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(TMSK_ADR)) |-> ((reg_rdata & 8'hB9) == 8'h00));
    // R3, R10: a compare pulse always leaves its flag set, even against a clear
    a_r10_cmp_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cmp |=> flag_cmp);
    // R4: a request is held only on a global enable seen one cycle earlier
    a_r4_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gie));
    // R5: vector always in the defined range
    a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec >= 3'd1 && irq_vec <= 3'd5));
    // R6: acknowledge drops the request and the global enable
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> (!irq && !gie));
    a_r6_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> (!irq || $stable(irq_vec)));
    // R8: external flag held clear in low-level mode
    a_r8_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_sense) == 2'b00) |-> !flag_ext);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .ADDR_W(ADDR_W), .GFLG_ADR(GFLG_ADR), .TMSK_ADR(TMSK_ADR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .ext_sense(ext_sense), .tmr_cmp(tmr_cmp), .flag_ext(flag_q[0]),
    .flag_cmp(flag_q[2]), .gie(gie), .irq(irq), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
    localparam logic [5:0] GMSK = 6'h3B, GFLG = 6'h3A, TMSK = 6'h39, TFLG = 6'h38;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       gie_wr = 1'b0, gie_wdata = 1'b0, gie;
    logic       ext_pin = 1'b0;
    logic [1:0] ext_sense = 2'b01;
    logic [5:0] pc_pins = '0;
    logic       tmr_cmp = 1'b0, tmr1_ovf = 1'b0, tmr0_ovf = 1'b0;
    logic       irq, irq_ack = 1'b0;
    logic [2:0] irq_vec;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie_wr(gie_wr),
        .gie_wdata(gie_wdata), .gie(gie), .ext_pin(ext_pin),
        .ext_sense(ext_sense), .pc_pins(pc_pins), .tmr_cmp(tmr_cmp),
        .tmr1_ovf(tmr1_ovf), .tmr0_ovf(tmr0_ovf), .irq(irq),
        .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    // {timer mask, pulses cmp/t1/t0, expected vector}
    localparam int NT = 6;
    localparam logic [13:0] TBL [NT] = '{
        {8'h46, 3'b111, 3'd3},
        {8'h06, 3'b111, 3'd4},
        {8'h02, 3'b111, 3'd5},
        {8'h44, 3'b011, 3'd4},
        {8'h42, 3'b001, 3'd5},
        {8'h00, 3'b111, 3'd0}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic set_gie(logic v);
        @(negedge clk); gie_wr = 1'b1; gie_wdata = v;
        @(negedge clk); gie_wr = 1'b0;
    endtask

    task automatic pulse(logic [2:0] p);
        @(negedge clk); {tmr_cmp, tmr1_ovf, tmr0_ovf} = p;
        @(negedge clk); {tmr_cmp, tmr1_ovf, tmr0_ovf} = 3'b000;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] tbits(logic [2:0] p);
        return {1'b0, p[2], 3'b000, p[1], p[0], 1'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(GMSK, d); check("R1 gmask", d, 8'h00);
        rd(GFLG, d); check("R1 gflag", d, 8'h00);
        rd(TMSK, d); check("R1 tmask", d, 8'h00);
        rd(TFLG, d); check("R1 tflag", d, 8'h00);
        check("R1 gie/irq", {gie, irq}, 2'b00);

        // R2 map and reserved bits
        wr(GMSK, 8'hFF); rd(GMSK, d); check("R2 gmask", d, 8'h60);
        wr(TMSK, 8'hFF); rd(TMSK, d); check("R2 tmask", d, 8'h46);
        wr(6'h20, 8'hFF); rd(6'h20, d); check("R2 unmapped", d, 8'h00);
        wr(GMSK, 8'h00); wr(TMSK, 8'h00);

        // R10 / R3 set, write-zero, write-one-clear
        pulse(3'b100); rd(TFLG, d); check("R10 cmp flag", d, 8'h40);
        pulse(3'b011); rd(TFLG, d); check("R10 ovf flags", d, 8'h46);
        wr(TFLG, 8'h00); rd(TFLG, d); check("R3 write zero", d, 8'h46);
        wr(TFLG, 8'h44); rd(TFLG, d); check("R3 w1c", d, 8'h02);
        wr(TFLG, 8'hFF);
        @(negedge clk); reg_addr = TFLG; reg_wdata = 8'h40; reg_wr = 1'b1; tmr_cmp = 1'b1;
        @(negedge clk); reg_wr = 1'b0; tmr_cmp = 1'b0;
        rd(TFLG, d); check("R3 set beats clear", d, 8'h40);
        wr(TFLG, 8'hFF);

        // R4 gating and withdrawal
        wr(TMSK, 8'h40); pulse(3'b100); idle(3);
        check("R4 no gie no irq", {7'b0, irq}, 8'h00);
        set_gie(1'b1); idle(2);
        check("R4 irq with gie", {4'b0, irq, irq_vec}, {4'b0, 1'b1, 3'd3});
        wr(TMSK, 8'h00); idle(2);
        check("R4 withdraw", {7'b0, irq}, 8'h00);
        set_gie(1'b0); wr(TFLG, 8'hFF);

        // R5 / R6 / R10 table
        for (int i = 0; i < NT; i++) begin
            logic [7:0] m; logic [2:0] p, v;
            {m, p, v} = TBL[i];
            wr(TFLG, 8'hFF); wr(TMSK, m); pulse(p); set_gie(1'b1); idle(3);
            check("R5 irq", {7'b0, irq}, {7'b0, v != 3'd0});
            if (v != 3'd0) begin
                check("R5 vector", {5'b0, irq_vec}, {5'b0, v});
                ack(); idle(1);
                rd(TFLG, d);
                check("R6 flag cleared", d,
                      tbits(p) & ~tbits(v == 3'd3 ? 3'b100 : v == 3'd4 ? 3'b010 : 3'b001));
                check("R6 gie/irq", {gie, irq}, 2'b00);
            end
            set_gie(1'b0);
        end
        wr(TFLG, 8'hFF); wr(TMSK, 8'h00);

        // R7 edge modes
        ext_sense = 2'b10; idle(1);
        ext_pin = 1'b1; idle(5); rd(GFLG, d); check("R7 fall ignores rise", d, 8'h00);
        ext_pin = 1'b0; idle(5); rd(GFLG, d); check("R7 fall sets", d, 8'h40);
        wr(GFLG, 8'h40);
        ext_sense = 2'b11; idle(1);
        ext_pin = 1'b1; idle(5); rd(GFLG, d); check("R7 rise sets", d, 8'h40);
        wr(GFLG, 8'h40);
        ext_sense = 2'b01; idle(1);
        ext_pin = 1'b0; idle(5); rd(GFLG, d); check("R7 any sets", d, 8'h40);
        wr(GMSK, 8'h40); set_gie(1'b1); idle(2);
        check("R7 ext vector", {4'b0, irq, irq_vec}, {4'b0, 1'b1, 3'd1});
        ack(); idle(1); rd(GFLG, d); check("R6 ext ack clears", d, 8'h00);
        wr(GMSK, 8'h00);

        // R8 low level
        ext_sense = 2'b00; idle(1);
        ext_pin = 1'b1; idle(5); ext_pin = 1'b0; idle(5);
        rd(GFLG, d); check("R8 flag reads zero", d, 8'h00);
        wr(GMSK, 8'h40); set_gie(1'b1); idle(3);
        check("R8 level irq", {4'b0, irq, irq_vec}, {4'b0, 1'b1, 3'd1});
        ext_pin = 1'b1; idle(5); check("R8 high drops", {7'b0, irq}, 8'h00);
        ext_pin = 1'b0; idle(5); check("R8 low again", {7'b0, irq}, 8'h01);
        ack(); check("R8 ack", {gie, irq}, 2'b00);
        wr(GMSK, 8'h00); ext_sense = 2'b01; idle(2);

        // R9 pin change
        pc_pins = 6'b100000; idle(5); rd(GFLG, d); check("R9 one pin", d, 8'h20);
        wr(GFLG, 8'h20); rd(GFLG, d); check("R9 cleared", d, 8'h00);
        pc_pins = 6'b000011; idle(5); rd(GFLG, d); check("R9 several pins", d, 8'h20);

        // R5 priority across all groups
        ext_pin = 1'b1; pulse(3'b100); idle(5);
        wr(GMSK, 8'h60); wr(TMSK, 8'h46); set_gie(1'b1); idle(2);
        check("R5 ext first", {5'b0, irq_vec}, 8'd1);
        ack(); rd(GFLG, d); check("R5 pc left", d, 8'h20);
        set_gie(1'b1); idle(2);
        check("R5 pc second", {5'b0, irq_vec}, 8'd2);
        ack(); set_gie(1'b1); idle(2);
        check("R5 cmp third", {5'b0, irq_vec}, 8'd3);
        ack(); idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule